// File: doc/BRIEF.md
# Interleaved Decoder Target Selector

This block answers one question for a memory fabric: given a host physical address, which downstream port should carry the access? It holds one programmable decoder. A control word carries a commit flag, a granularity code and a ways code. Two 32-bit list words carry up to eight 8-bit downstream port numbers.

Software-side logic loads the three words through a simple write port. A lookup request presents an address. One cycle later the block returns a valid strobe, a hit flag and the selected port number. The address is cut into interleave chunks of 256 bytes times two to the power of the granularity code. The chunk number, reduced modulo the way count, picks one byte of the port list. Entries 0 to 3 come from the low list word and entries 4 to 7 from the high one.

Top module: `ileave_target_sel`

## Requirements
- R1: After reset all three decoder words read as zero, so the decoder is uncommitted, and rspValid, rspHit and rspPort are 0.
- R2: A write with regWe high stores regWdata at the next clock edge. regAddr 0 selects the control word, 1 the low port list and 2 the high port list. A write to regAddr 3 changes nothing.
- R3: When control bit 0 (commit) is clear, a lookup returns rspHit 0 and rspPort 0.
- R4: The granularity code sits in control bits [7:4]. The interleave chunk size is 256 bytes shifted left by that code.
- R5: The ways code sits in control bits [11:8]. Codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 ways. The target index is (address / chunk size) modulo the way count.
- R6: Target index i in 0..3 selects bits [8i+7:8i] of the low port list as rspPort.
- R7: Target index i in 4..7 selects bits [8(i-4)+7:8(i-4)] of the high port list as rspPort.
- R8: A ways code above 3 gives rspHit 0 and rspPort 0, even when the decoder is committed.
- R9: rspValid is high for exactly the cycle after a cycle with reqValid high. When rspValid is low, rspHit and rspPort are 0.
- R10: A lookup issued in the same cycle as a register write uses the decoder contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 2 | Register select |
| regWdata | input | 32 | Register write data |
| reqValid | input | 1 | Lookup request |
| reqAddr | input | 48 | Lookup host physical address |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Target found |
| rspPort | output | 8 | Selected downstream port number |

## Verification
The hardest case to reach from the ports is a lookup issued in the same cycle as a write that changes the decoder. Here the result must reflect the old contents. The bench drives write and request in one cycle, both turning commit off and rewriting a list lane that the address selects. To tell neighbouring lanes apart, it uses a distinct port number in every list byte. It sweeps addresses across chunk boundaries at several granularities and way counts, including illegal ways codes. Random traffic then mixes writes and lookups on every clock, and a behavioural model checks each result.

// File: rtl/ileave_sel_pkg.sv
package ileave_sel_pkg;
  localparam int COMMIT_BIT = 0;
  localparam int GRAN_LSB   = 4;
  localparam int GRAN_W     = 4;
  localparam int WAYS_LSB   = 8;
  localparam int WAYS_W     = 4;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_LO   = 2'd1;
  localparam logic [1:0] RA_HI   = 2'd2;

  typedef struct packed {
    logic ldCtrl;
    logic ldLo;
    logic ldHi;
    logic lookup;
  } selStrobe_t;
endpackage

// File: rtl/ileave_sel_ctrl.sv
module ileave_sel_ctrl
  import ileave_sel_pkg::*;
#(
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              reqValid,
  output selStrobe_t        st,
  output logic              rspValid
);
  always_comb begin
    st        = '0;
    st.ldCtrl = regWe && (regAddr == REG_AW'(RA_CTRL));
    st.ldLo   = regWe && (regAddr == REG_AW'(RA_LO));
    st.ldHi   = regWe && (regAddr == REG_AW'(RA_HI));
    st.lookup = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= st.lookup;
  end

  a_r2_onehot_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.ldCtrl, st.ldLo, st.ldHi}));
endmodule

// File: rtl/ileave_sel_dpath.sv
module ileave_sel_dpath
  import ileave_sel_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int PORT_W     = 8,
  parameter int LANES      = 4,
  parameter int GRAN_SHIFT = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  selStrobe_t            st,
  input  logic [LANES*PORT_W-1:0] wrData,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  rspHit,
  output logic [PORT_W-1:0]     rspPort
);
  localparam int DATA_W  = LANES * PORT_W;
  localparam int ENTRIES = 2 * LANES;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int SH_W    = $clog2(ADDR_W) + 1;

  logic [DATA_W-1:0] ctrlReg, loReg, hiReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      loReg   <= '0;
      hiReg   <= '0;
    end else begin
      if (st.ldCtrl) ctrlReg <= wrData;
      if (st.ldLo)   loReg   <= wrData;
      if (st.ldHi)   hiReg   <= wrData;
    end
  end

  logic              committed;
  logic [GRAN_W-1:0] granCode;
  logic [WAYS_W-1:0] waysCode;
  assign committed = ctrlReg[COMMIT_BIT];
  assign granCode  = ctrlReg[GRAN_LSB +: GRAN_W];
  assign waysCode  = ctrlReg[WAYS_LSB +: WAYS_W];

  logic [SH_W-1:0]   shAmt;
  logic [ADDR_W-1:0] chunkNum;
  logic [IDX_W-1:0]  idxMask, tgtIdx;
  logic              waysOk;

  assign shAmt    = SH_W'(GRAN_SHIFT) + SH_W'(granCode);
  assign chunkNum = reqAddr >> shAmt;
  assign waysOk   = (waysCode <= WAYS_W'(IDX_W));

  for (genvar b = 0; b < IDX_W; b++) begin : g_mask
    assign idxMask[b] = (waysCode > WAYS_W'(b));
  end
  assign tgtIdx = chunkNum[IDX_W-1:0] & idxMask;

  logic [PORT_W-1:0] laneSel [ENTRIES];
  for (genvar e = 0; e < ENTRIES; e++) begin : g_lane
    if (e < LANES) begin : g_lo
      assign laneSel[e] = loReg[e*PORT_W +: PORT_W];
    end else begin : g_hi
      assign laneSel[e] = hiReg[(e-LANES)*PORT_W +: PORT_W];
    end
  end

  logic hitNow;
  assign hitNow = committed && waysOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHit  <= 1'b0;
      rspPort <= '0;
    end else if (st.lookup && hitNow) begin
      rspHit  <= 1'b1;
      rspPort <= laneSel[tgtIdx];
    end else begin
      rspHit  <= 1'b0;
      rspPort <= '0;
    end
  end

  // R3: uncommitted decoder never reports a target
  a_r3_uncommitted_miss: assert property (@(posedge clk) disable iff (!rstN)
    (st.lookup && !ctrlReg[COMMIT_BIT]) |=> !rspHit);
  // R8: illegal way count never reports a target
  a_r8_bad_ways_miss: assert property (@(posedge clk) disable iff (!rstN)
    (st.lookup && (ctrlReg[WAYS_LSB +: WAYS_W] > WAYS_W'(IDX_W))) |=> !rspHit);
  // R2: control word holds without a load strobe
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !st.ldCtrl |=> $stable(ctrlReg));
endmodule

// File: rtl/ileave_target_sel.sv
module ileave_target_sel
  import ileave_sel_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int PORT_W = 8,
  parameter int LANES  = 4,
  parameter int REG_AW = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [REG_AW-1:0]       regAddr,
  input  logic [LANES*PORT_W-1:0] regWdata,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqAddr,
  output logic                    rspValid,
  output logic                    rspHit,
  output logic [PORT_W-1:0]       rspPort
);
  selStrobe_t st;

  ileave_sel_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .reqValid(reqValid), .st(st), .rspValid(rspValid)
  );

  ileave_sel_dpath #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .LANES(LANES)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .wrData(regWdata), .reqAddr(reqAddr),
    .rspHit(rspHit), .rspPort(rspPort)
  );

  // R9: no hit or port without a valid response
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspHit && rspPort == '0));
  // R9: response follows a request by one cycle
  a_r9_valid_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
endmodule

// File: tb/ileave_target_sel_tb.sv
module ileave_target_sel_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        reqValid = 1'b0;
  logic [47:0] reqAddr = '0;
  logic        rspValid, rspHit;
  logic [7:0]  rspPort;

  always #5 clk = ~clk;

  ileave_target_sel u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .reqValid(reqValid), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspPort(rspPort)
  );

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  bit done = 1'b0;

  // behavioural model state
  longint unsigned mCtrl = 0, mLo = 0, mHi = 0;
  bit      eValid = 0, eHit = 0;
  int      ePort = 0;
  bit      modelLive = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mLo = 0; mHi = 0;
      eValid = 0; eHit = 0; ePort = 0;
      modelLive = 1;
    end else begin
      eValid = reqValid;
      eHit = 0; ePort = 0;
      if (reqValid) begin
        longint unsigned gran, ways, idx;
        gran = 64'd256 << ((mCtrl >> 4) & 15);
        if ((mCtrl & 1) == 1 && ((mCtrl >> 8) & 15) <= 3) begin
          ways = 64'd1 << ((mCtrl >> 8) & 15);
          idx  = (longint'(reqAddr) / gran) % ways;
          eHit = 1;
          if (idx < 4) ePort = int'((mLo >> (idx * 8)) & 255);
          else         ePort = int'((mHi >> ((idx - 4) * 8)) & 255);
        end
      end
      if (regWe) begin
        if (regAddr == 0) mCtrl = regWdata;
        else if (regAddr == 1) mLo = regWdata;
        else if (regAddr == 2) mHi = regWdata;
      end
    end
  end

  always @(negedge clk) begin
    if (modelLive && !done) begin
      checks++;
      if (rspValid !== eValid || rspHit !== eHit || int'(rspPort) !== ePort ||
          $isunknown({rspValid, rspHit, rspPort})) begin
        failures++;
        $display("FAIL %s: got valid=%0b hit=%0b port=%0h, expected valid=%0b hit=%0b port=%0h",
                 curReq, rspValid, rspHit, rspPort, eValid, eHit, ePort);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic look(input logic [47:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  function automatic logic [31:0] ctrlWord(input bit c, input int g, input int w);
    return 32'(c) | (32'(g & 15) << 4) | (32'(w & 15) << 8);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, lookup after reset misses
    curReq = "R1";
    repeat (2) @(negedge clk);
    look(48'h1234_5600);
    // R2 / R6 / R7: program lists and 8 ways at 256 B
    curReq = "R2";
    wr(2'd1, 32'h1312_1110);
    wr(2'd2, 32'h1716_1514);
    wr(2'd0, ctrlWord(1, 0, 3));
    curReq = "R6";
    for (int i = 0; i < 4; i++) look(48'(i * 256 + 17));
    curReq = "R7";
    for (int i = 4; i < 8; i++) look(48'(i * 256 + 255));
    // R5: wrap past 8 chunks
    curReq = "R5";
    look(48'(9 * 256));
    look(48'hFFFF_FFFF_FF00);
    // R4: 1 KiB granularity, 4 ways
    curReq = "R4";
    wr(2'd0, ctrlWord(1, 2, 2));
    for (int i = 0; i < 6; i++) look(48'(i * 1024 + 512));
    look(48'd1023);
    // R5: 1 way always lane 0, 2 ways
    curReq = "R5";
    wr(2'd0, ctrlWord(1, 5, 0));
    look(48'h0007_7000);
    wr(2'd0, ctrlWord(1, 1, 1));
    look(48'd512); look(48'd1024);
    // R8: illegal ways codes
    curReq = "R8";
    wr(2'd0, ctrlWord(1, 0, 4));
    look(48'd256);
    wr(2'd0, ctrlWord(1, 0, 15));
    look(48'd768);
    // R3: uncommitted
    curReq = "R3";
    wr(2'd0, ctrlWord(0, 0, 3));
    look(48'd512);
    // R2: writes to address 3 ignored
    curReq = "R2";
    wr(2'd0, ctrlWord(1, 0, 3));
    wr(2'd3, 32'hFFFF_FFFF);
    look(48'd0); look(48'd1792);
    // R10: write and lookup in same cycle
    curReq = "R10";
    @(negedge clk);
    regWe = 1'b1; regAddr = 2'd0; regWdata = ctrlWord(0, 0, 3);
    reqValid = 1'b1; reqAddr = 48'd512;
    @(negedge clk);
    regWe = 1'b0; reqValid = 1'b0;
    wr(2'd0, ctrlWord(1, 0, 3));
    @(negedge clk);
    regWe = 1'b1; regAddr = 2'd1; regWdata = 32'hAAAA_AAAA;
    reqValid = 1'b1; reqAddr = 48'd256;
    @(negedge clk);
    regWe = 1'b0; reqValid = 1'b0;
    look(48'd256);
    // R9: idle cycles and back-to-back requests
    curReq = "R9";
    repeat (3) @(negedge clk);
    @(negedge clk); reqValid = 1'b1; reqAddr = 48'd0;
    @(negedge clk); reqAddr = 48'd1536;
    @(negedge clk); reqValid = 1'b0;
    // random mix
    curReq = "R5";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      regWe    = ($urandom_range(0, 3) == 0);
      regAddr  = 2'($urandom_range(0, 3));
      regWdata = ($urandom_range(0, 1) == 1) ? ($urandom & 32'h0000_03F1) | 32'h1 : $urandom;
      reqValid = ($urandom_range(0, 1) == 1);
      reqAddr  = {16'($urandom), 32'($urandom)};
    end
    @(negedge clk);
    regWe = 1'b0; reqValid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule